// File: doc/BRIEF.md
# Memory Access Watch Unit

This block snoops a memory bus and flags reads and writes that fall inside address windows chosen by software. Four general windows each take an inclusive lower and upper bound. Two further windows sit at fixed bases, which are set by parameter. Each of these is cut into 32 slices of 4 KiB. A per-slice include mask picks which slices are watched, and per-slice sticky bitmaps record which slices have been read or written.

Every window has one event for write hits and one for read hits, so there are twelve events. Software arms each event through a watch mask. It routes the events to a maskable interrupt and, through a separate enable mask, to a non-maskable interrupt. The three masks use set/clear register pairs. The unit only observes the bus and never stalls it.

The monitored bus is a valid-only beat stream (`mon_valid`, `mon_write`, `mon_addr`). The unit has no ready signal and takes every beat on which `mon_valid` is high, so it puts no back-pressure on the bus. Beats may arrive on consecutive cycles. The register port is a write strobe with a word address. Read data is a combinational function of `reg_addr`.

Top module: `mem_watch_unit`

## Requirements
- R1: After reset, every mask, bound, event and slice bitmap reads 0, and `irq` and `nmi` are 0.
- R2: There are three 12-bit masks: watch, interrupt enable and non-maskable enable. Each has a set address (0x00, 0x02, 0x04) and a clear address (0x01, 0x03, 0x05). Writing the set address ORs the written bits into the mask. Writing the clear address removes the written bits. Reading either address returns the mask.
- R3: General window w (0..3) has its lower bound at 0x20+2w and its upper bound at 0x21+2w. A beat hits the window when lower <= address <= upper. A window whose lower bound is above its upper bound never hits. A write hit raises event 2w and a read hit raises event 2w+1.
- R4: A hit raises its event only if the watch mask bit with the same index was 1 in the cycle of the beat. Without that bit the hit leaves the event unchanged.
- R5: Event e reads at 0x10+e, in bit 0. Writing a word with bit 0 equal to 0 clears the event. Writing a word with bit 0 equal to 1 does nothing. If a hit and a clear fall in the same cycle, the event ends up set.
- R6: Fixed window p (0..1) spans 128 KiB from its base. The slice index is address bits [16:12]. A hit needs the slice's bit set in the include mask at 0x30+p. A write hit raises event 8+2p and a read hit raises event 9+2p.
- R7: Fixed window p has a read bitmap at 0x34+p and a write bitmap at 0x38+p. A watched hit sets the bit of its slice, and that bit stays set. Writing a mask clears the bits that are 1 in it. A set wins over a clear in the same cycle.
- R8: `irq` is registered. One cycle after any event whose interrupt-enable bit is set, `irq` is 1.
- R9: `nmi` is registered. One cycle after any event whose non-maskable enable bit is set, `nmi` is 1. This is independent of `irq`.
- R10: Beats on consecutive cycles are each detected, and the unit has no way to stall them.
- R11: A beat outside a fixed window's 128 KiB span, or inside a slice left out of the include mask, raises no event and sets no bitmap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_valid | input | 1 | Monitored beat present |
| mon_write | input | 1 | Beat is a write (1) or a read (0) |
| mon_addr | input | 32 | Beat address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Maskable interrupt |
| nmi | output | 1 | Non-maskable interrupt |

## Verification
The hardest cases to reach are a software clear and a new hit landing in the same clock. This applies to both an event flag and a slice bitmap bit. The bench's cycle task drives a register write and a bus beat together on one edge, which lines up the two in a single cycle. A behavioural model then decides which one survives. The bench also covers edge addresses: the exact bounds, one past them, an inverted window, and the first address beyond a fixed window. Reads at every register address after each phase expose any state the stimulus could have disturbed.

// File: rtl/mwu_pkg.sv
`timescale 1ns/1ps
package mwu_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int REG_AW = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  // register word addresses
  localparam int OFS_WATCH_SET = 'h00;
  localparam int OFS_WATCH_CLR = 'h01;
  localparam int OFS_IEN_SET   = 'h02;
  localparam int OFS_IEN_CLR   = 'h03;
  localparam int OFS_NEN_SET   = 'h04;
  localparam int OFS_NEN_CLR   = 'h05;
  localparam int OFS_EVT       = 'h10;
  localparam int OFS_USR       = 'h20;
  localparam int OFS_SUBM      = 'h30;
  localparam int OFS_RSTAT     = 'h34;
  localparam int OFS_WSTAT     = 'h38;
endpackage

// File: rtl/mwu_user_win.sv
`timescale 1ns/1ps
module mwu_user_win
  import mwu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lo_we,
  input  logic  hi_we,
  input  word_t wdata,
  input  addr_t mon_addr,
  output addr_t lo,
  output addr_t hi,
  output logic  match
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      if (lo_we) lo <= wdata;
      if (hi_we) hi <= wdata;
    end
  end

  // inclusive bounds on both sides
  assign match = (mon_addr >= lo) && (mon_addr <= hi);

  // an inverted window must stay silent
  assert_inverted_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo > hi) |-> !match);
endmodule

// File: rtl/mwu_periph_win.sv
`timescale 1ns/1ps
module mwu_periph_win
  import mwu_pkg::*;
#(
  parameter addr_t BASE      = 32'h4000_0000,
  parameter int    SUB_NUM   = 32,
  parameter int    SUB_SHIFT = 12
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mon_valid,
  input  logic               mon_write,
  input  addr_t              mon_addr,
  input  logic               watch_wr,
  input  logic               watch_rd,
  input  logic               mask_we,
  input  logic               rclr_we,
  input  logic               wclr_we,
  input  word_t              wdata,
  output logic [SUB_NUM-1:0] sub_mask,
  output logic [SUB_NUM-1:0] rd_stat,
  output logic [SUB_NUM-1:0] wr_stat,
  output logic               in_sel
);
  localparam int IDX_W     = $clog2(SUB_NUM);
  localparam int WIN_SHIFT = SUB_SHIFT + IDX_W;

  logic               in_window;
  logic [IDX_W-1:0]   sub_idx;
  logic [SUB_NUM-1:0] sub_hot;
  logic [SUB_NUM-1:0] rd_set;
  logic [SUB_NUM-1:0] wr_set;
  logic [SUB_NUM-1:0] rd_clr;
  logic [SUB_NUM-1:0] wr_clr;

  // window is aligned to its own span, so an upper-bit match suffices
  assign in_window = (mon_addr[ADDR_W-1:WIN_SHIFT] == BASE[ADDR_W-1:WIN_SHIFT]);
  assign sub_idx   = mon_addr[WIN_SHIFT-1:SUB_SHIFT];
  assign sub_hot   = SUB_NUM'(1) << sub_idx;
  assign in_sel    = in_window && sub_mask[sub_idx];

  assign rd_set = (mon_valid && !mon_write && watch_rd && in_sel) ? sub_hot : '0;
  assign wr_set = (mon_valid &&  mon_write && watch_wr && in_sel) ? sub_hot : '0;
  assign rd_clr = rclr_we ? wdata[SUB_NUM-1:0] : '0;
  assign wr_clr = wclr_we ? wdata[SUB_NUM-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_mask <= '0;
      rd_stat  <= '0;
      wr_stat  <= '0;
    end else begin
      if (mask_we) sub_mask <= wdata[SUB_NUM-1:0];
      rd_stat <= (rd_stat & ~rd_clr) | rd_set;   // set beats clear
      wr_stat <= (wr_stat & ~wr_clr) | wr_set;
    end
  end

  assert_rd_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rclr_we |=> ((rd_stat & $past(rd_stat)) == $past(rd_stat)));
  assert_wr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wclr_we |=> ((wr_stat & $past(wr_stat)) == $past(wr_stat)));
  assert_rd_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && !mon_write && watch_rd && in_window && sub_mask[sub_idx])
    |=> rd_stat[$past(sub_idx)]);
  assert_wr_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && mon_write && watch_wr && in_window && sub_mask[sub_idx])
    |=> wr_stat[$past(sub_idx)]);
  assert_outside_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> !in_sel);
endmodule

// File: rtl/mem_watch_unit.sv
`timescale 1ns/1ps
module mem_watch_unit
  import mwu_pkg::*;
#(
  parameter int                      NUM_USER  = 4,
  parameter int                      NUM_PER   = 2,
  parameter int                      SUB_NUM   = 32,
  parameter int                      SUB_SHIFT = 12,
  parameter logic [NUM_PER*ADDR_W-1:0] PER_BASES = {32'h5000_0000, 32'h4000_0000}
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_valid,
  input  logic              mon_write,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              nmi
);
  localparam int NUM_WIN  = NUM_USER + NUM_PER;
  localparam int NUM_EVT  = 2 * NUM_WIN;
  localparam int PER_EVT0 = 2 * NUM_USER;

  logic [NUM_EVT-1:0] watch_en, irq_en, nmi_en, evt;
  logic [NUM_EVT-1:0] hit_raw, evt_clr;
  logic               irq_q, nmi_q;

  addr_t              usr_lo [NUM_USER];
  addr_t              usr_hi [NUM_USER];
  logic               usr_match [NUM_USER];
  logic [SUB_NUM-1:0] per_mask  [NUM_PER];
  logic [SUB_NUM-1:0] per_rstat [NUM_PER];
  logic [SUB_NUM-1:0] per_wstat [NUM_PER];
  logic               per_sel   [NUM_PER];

  logic sel_wset, sel_wclr, sel_iset, sel_iclr, sel_nset, sel_nclr;
  assign sel_wset = reg_wr && (reg_addr == REG_AW'(OFS_WATCH_SET));
  assign sel_wclr = reg_wr && (reg_addr == REG_AW'(OFS_WATCH_CLR));
  assign sel_iset = reg_wr && (reg_addr == REG_AW'(OFS_IEN_SET));
  assign sel_iclr = reg_wr && (reg_addr == REG_AW'(OFS_IEN_CLR));
  assign sel_nset = reg_wr && (reg_addr == REG_AW'(OFS_NEN_SET));
  assign sel_nclr = reg_wr && (reg_addr == REG_AW'(OFS_NEN_CLR));

  // general windows: write hit on even event, read hit on odd
  for (genvar w = 0; w < NUM_USER; w++) begin : g_user
    mwu_user_win u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .lo_we    (reg_wr && (reg_addr == REG_AW'(OFS_USR + 2*w))),
      .hi_we    (reg_wr && (reg_addr == REG_AW'(OFS_USR + 2*w + 1))),
      .wdata    (reg_wdata),
      .mon_addr (mon_addr),
      .lo       (usr_lo[w]),
      .hi       (usr_hi[w]),
      .match    (usr_match[w])
    );
    assign hit_raw[2*w]   = mon_valid &&  mon_write && usr_match[w];
    assign hit_raw[2*w+1] = mon_valid && !mon_write && usr_match[w];
  end

  // fixed sliced windows follow the general ones in event order
  for (genvar p = 0; p < NUM_PER; p++) begin : g_per
    mwu_periph_win #(
      .BASE      (PER_BASES[p*ADDR_W +: ADDR_W]),
      .SUB_NUM   (SUB_NUM),
      .SUB_SHIFT (SUB_SHIFT)
    ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .mon_valid (mon_valid),
      .mon_write (mon_write),
      .mon_addr  (mon_addr),
      .watch_wr  (watch_en[PER_EVT0 + 2*p]),
      .watch_rd  (watch_en[PER_EVT0 + 2*p + 1]),
      .mask_we   (reg_wr && (reg_addr == REG_AW'(OFS_SUBM + p))),
      .rclr_we   (reg_wr && (reg_addr == REG_AW'(OFS_RSTAT + p))),
      .wclr_we   (reg_wr && (reg_addr == REG_AW'(OFS_WSTAT + p))),
      .wdata     (reg_wdata),
      .sub_mask  (per_mask[p]),
      .rd_stat   (per_rstat[p]),
      .wr_stat   (per_wstat[p]),
      .in_sel    (per_sel[p])
    );
    assign hit_raw[PER_EVT0 + 2*p]     = mon_valid &&  mon_write && per_sel[p];
    assign hit_raw[PER_EVT0 + 2*p + 1] = mon_valid && !mon_write && per_sel[p];
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt_clr
    assign evt_clr[e] = reg_wr && (reg_addr == REG_AW'(OFS_EVT + e)) && !reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      watch_en <= '0;
      irq_en   <= '0;
      nmi_en   <= '0;
    end else begin
      if (sel_wset)      watch_en <= watch_en |  reg_wdata[NUM_EVT-1:0];
      else if (sel_wclr) watch_en <= watch_en & ~reg_wdata[NUM_EVT-1:0];
      if (sel_iset)      irq_en   <= irq_en   |  reg_wdata[NUM_EVT-1:0];
      else if (sel_iclr) irq_en   <= irq_en   & ~reg_wdata[NUM_EVT-1:0];
      if (sel_nset)      nmi_en   <= nmi_en   |  reg_wdata[NUM_EVT-1:0];
      else if (sel_nclr) nmi_en   <= nmi_en   & ~reg_wdata[NUM_EVT-1:0];
    end
  end

  // a watched hit in the same cycle as a clear leaves the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= (evt & ~evt_clr) | (hit_raw & watch_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      irq_q <= |(evt & irq_en);
      nmi_q <= |(evt & nmi_en);
    end
  end

  assign irq = irq_q;
  assign nmi = nmi_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(OFS_WATCH_SET) || reg_addr == REG_AW'(OFS_WATCH_CLR))
      reg_rdata = DATA_W'(watch_en);
    if (reg_addr == REG_AW'(OFS_IEN_SET) || reg_addr == REG_AW'(OFS_IEN_CLR))
      reg_rdata = DATA_W'(irq_en);
    if (reg_addr == REG_AW'(OFS_NEN_SET) || reg_addr == REG_AW'(OFS_NEN_CLR))
      reg_rdata = DATA_W'(nmi_en);
    for (int e = 0; e < NUM_EVT; e++)
      if (reg_addr == REG_AW'(OFS_EVT + e)) reg_rdata = DATA_W'(evt[e]);
    for (int w = 0; w < NUM_USER; w++) begin
      if (reg_addr == REG_AW'(OFS_USR + 2*w))     reg_rdata = usr_lo[w];
      if (reg_addr == REG_AW'(OFS_USR + 2*w + 1)) reg_rdata = usr_hi[w];
    end
    for (int p = 0; p < NUM_PER; p++) begin
      if (reg_addr == REG_AW'(OFS_SUBM + p))  reg_rdata = DATA_W'(per_mask[p]);
      if (reg_addr == REG_AW'(OFS_RSTAT + p)) reg_rdata = DATA_W'(per_rstat[p]);
      if (reg_addr == REG_AW'(OFS_WSTAT + p)) reg_rdata = DATA_W'(per_wstat[p]);
    end
  end

  assert_watch_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wset |=> ((watch_en & $past(reg_wdata[NUM_EVT-1:0])) == $past(reg_wdata[NUM_EVT-1:0])));
  assert_watch_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wclr |=> ((watch_en & $past(reg_wdata[NUM_EVT-1:0])) == '0));
  assert_evt_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~$past(evt) & ~$past(watch_en)) == '0));
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_raw & watch_en)) |=> ((evt & $past(hit_raw & watch_en)) == $past(hit_raw & watch_en)));
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & irq_en)) |=> irq);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_en) == '0) |-> !irq);
  assert_nmi_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & nmi_en)) |=> nmi);
  assert_nmi_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nmi_en) == '0) |-> !nmi);
endmodule

// File: tb/mem_watch_unit_bench.sv
`timescale 1ns/1ps
module mem_watch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, nmi;

  always #2 clk = ~clk;   // 250 MHz

  mem_watch_unit u_mem_watch_unit (
    .clk(clk), .rst_n(rst_n),
    .mon_valid(bus_valid), .mon_write(bus_write), .mon_addr(bus_addr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .nmi(nmi)
  );

  localparam bit [31:0] PB0 = 32'h4000_0000;
  localparam bit [31:0] PB1 = 32'h5000_0000;

  // behavioural reference state
  bit [11:0] m_watch, m_ie, m_ne, m_evt;
  bit [31:0] m_lo [4];
  bit [31:0] m_hi [4];
  bit [31:0] m_subm [2];
  bit [31:0] m_rs [2];
  bit [31:0] m_ws [2];
  bit        m_irq, m_nmi;
  bit [11:0] hv, ev_clr;
  bit [31:0] rs_set [2];
  bit [31:0] ws_set [2];
  bit [31:0] off;
  int        sidx;

  int    n_cmp = 0, n_bad = 0;
  bit    cmp_on = 1'b0, done = 1'b0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_watch = '0; m_ie = '0; m_ne = '0; m_evt = '0; m_irq = 0; m_nmi = 0;
      for (int i = 0; i < 4; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
      for (int i = 0; i < 2; i++) begin m_subm[i] = '0; m_rs[i] = '0; m_ws[i] = '0; end
    end else begin
      m_irq = |(m_evt & m_ie);
      m_nmi = |(m_evt & m_ne);
      hv = '0;
      for (int p = 0; p < 2; p++) begin rs_set[p] = '0; ws_set[p] = '0; end
      if (bus_valid) begin
        for (int w = 0; w < 4; w++)
          if (bus_addr >= m_lo[w] && bus_addr <= m_hi[w]) hv[2*w + (bus_write ? 0 : 1)] = 1'b1;
        for (int p = 0; p < 2; p++) begin
          off = bus_addr - (p == 0 ? PB0 : PB1);
          if (bus_addr >= (p == 0 ? PB0 : PB1) && off < 32'h2_0000) begin
            sidx = int'(off / 32'h1000);
            if (m_subm[p][sidx]) begin
              hv[8 + 2*p + (bus_write ? 0 : 1)] = 1'b1;
              if (bus_write && m_watch[8 + 2*p])  ws_set[p][sidx] = 1'b1;
              if (!bus_write && m_watch[9 + 2*p]) rs_set[p][sidx] = 1'b1;
            end
          end
        end
      end
      hv = hv & m_watch;
      ev_clr = '0;
      if (reg_wr) begin
        case (reg_addr)
          8'h00: m_watch = m_watch | reg_wdata[11:0];
          8'h01: m_watch = m_watch & ~reg_wdata[11:0];
          8'h02: m_ie = m_ie | reg_wdata[11:0];
          8'h03: m_ie = m_ie & ~reg_wdata[11:0];
          8'h04: m_ne = m_ne | reg_wdata[11:0];
          8'h05: m_ne = m_ne & ~reg_wdata[11:0];
          8'h30: m_subm[0] = reg_wdata;
          8'h31: m_subm[1] = reg_wdata;
          8'h34: m_rs[0] = m_rs[0] & ~reg_wdata;
          8'h35: m_rs[1] = m_rs[1] & ~reg_wdata;
          8'h38: m_ws[0] = m_ws[0] & ~reg_wdata;
          8'h39: m_ws[1] = m_ws[1] & ~reg_wdata;
          default: ;
        endcase
        if (reg_addr >= 8'h10 && reg_addr < 8'h1C && !reg_wdata[0]) ev_clr[reg_addr - 8'h10] = 1'b1;
        if (reg_addr >= 8'h20 && reg_addr < 8'h28) begin
          if (reg_addr[0]) m_hi[(reg_addr - 8'h20) / 2] = reg_wdata;
          else             m_lo[(reg_addr - 8'h20) / 2] = reg_wdata;
        end
      end
      m_evt = (m_evt & ~ev_clr) | hv;
      for (int p = 0; p < 2; p++) begin
        m_rs[p] = m_rs[p] | rs_set[p];
        m_ws[p] = m_ws[p] | ws_set[p];
      end
    end
  end

  function automatic bit [31:0] exp_rd(bit [7:0] a);
    if (a == 8'h00 || a == 8'h01) return 32'(m_watch);
    if (a == 8'h02 || a == 8'h03) return 32'(m_ie);
    if (a == 8'h04 || a == 8'h05) return 32'(m_ne);
    if (a >= 8'h10 && a < 8'h1C) return 32'(m_evt[a - 8'h10]);
    if (a >= 8'h20 && a < 8'h28) return a[0] ? m_hi[(a - 8'h20) / 2] : m_lo[(a - 8'h20) / 2];
    if (a == 8'h30 || a == 8'h31) return m_subm[a - 8'h30];
    if (a == 8'h34 || a == 8'h35) return m_rs[a - 8'h34];
    if (a == 8'h38 || a == 8'h39) return m_ws[a - 8'h38];
    return '0;
  endfunction

  task automatic check();
    bit [31:0] er;
    if (!cmp_on) return;
    er = exp_rd(reg_addr);
    n_cmp += 3;
    if (irq !== m_irq) begin
      n_bad++; $display("FAIL %s irq: got %0b expected %0b", cur_req, irq, m_irq);
    end
    if (nmi !== m_nmi) begin
      n_bad++; $display("FAIL %s nmi: got %0b expected %0b", cur_req, nmi, m_nmi);
    end
    if (reg_rdata !== er) begin
      n_bad++; $display("FAIL %s rdata @%h: got %h expected %h", cur_req, reg_addr, reg_rdata, er);
    end
  endtask

  task automatic cyc(input bit v, input bit w, input bit [31:0] a,
                     input bit rw, input bit [7:0] ra, input bit [31:0] wd);
    @(negedge clk);
    check();
    bus_valid = v; bus_write = w; bus_addr = a;
    reg_wr = rw; reg_addr = ra; reg_wdata = wd;
  endtask

  task automatic wreg(input bit [7:0] a, input bit [31:0] d); cyc(0, 0, 0, 1, a, d); endtask
  task automatic rd(input bit [7:0] a);                        cyc(0, 0, 0, 0, a, 0); endtask
  task automatic beat(input bit w, input bit [31:0] a);        cyc(1, w, a, 0, reg_addr, 0); endtask
  task automatic clr_all();
    for (int e = 0; e < 12; e++) wreg(8'(8'h10 + e), 0);
  endtask
  task automatic rd_evts();
    for (int e = 0; e < 12; e++) rd(8'(8'h10 + e));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    cur_req = "R1";
    rd(8'h00); rd(8'h02); rd(8'h04); rd(8'h10); rd(8'h1B);
    rd(8'h20); rd(8'h27); rd(8'h30); rd(8'h34); rd(8'h39);

    cur_req = "R2";
    wreg(8'h00, 32'h0F0); rd(8'h01);
    wreg(8'h01, 32'h030); rd(8'h00);
    wreg(8'h02, 32'hA5A); wreg(8'h03, 32'h00A); rd(8'h03);
    wreg(8'h04, 32'h3C3); wreg(8'h05, 32'hFFF); rd(8'h04);
    wreg(8'h03, 32'hFFF); rd(8'h02);
    wreg(8'h00, 32'hFFF); rd(8'h00);

    cur_req = "R3";
    wreg(8'h20, 32'h1000); wreg(8'h21, 32'h1FFF);
    wreg(8'h22, 32'h3000); wreg(8'h23, 32'h2000);
    wreg(8'h24, 32'h0);    wreg(8'h25, 32'h0);
    wreg(8'h26, 32'h8000_0000); wreg(8'h27, 32'hFFFF_FFFF);
    rd(8'h23);
    beat(1, 32'h0FFF); rd(8'h10);
    beat(1, 32'h1000); rd(8'h10);
    beat(0, 32'h1FFF); beat(0, 32'h2000);
    beat(1, 32'h2800); beat(0, 32'h3000);
    beat(0, 32'h0);    beat(1, 32'hFFFF_FFFF);
    rd_evts();

    cur_req = "R4";
    clr_all(); rd_evts();
    wreg(8'h01, 32'h001);
    beat(1, 32'h1500); beat(0, 32'h1500);
    rd(8'h10); rd(8'h11);
    wreg(8'h00, 32'h001);

    cur_req = "R5";
    wreg(8'h11, 32'h1); rd(8'h11);
    wreg(8'h11, 32'hFFFF_FFFE); rd(8'h11);
    cyc(1, 1, 32'h1500, 1, 8'h10, 32'h0); rd(8'h10);
    cyc(1, 0, 32'h1800, 1, 8'h10, 32'h0); rd(8'h10); rd(8'h11);

    cur_req = "R11";
    clr_all();
    wreg(8'h30, 32'h8000_0008); rd(8'h30);
    beat(1, PB0 + 32'h5000); beat(0, PB0 + 32'h2_0000); beat(1, PB0 - 32'h4);
    rd(8'h18); rd(8'h19); rd(8'h34); rd(8'h38);

    cur_req = "R6";
    beat(1, PB0 + 32'h3010); rd(8'h18);
    beat(0, PB0 + 32'h1_FFFC); rd(8'h19);
    wreg(8'h31, 32'hFFFF_FFFF);
    beat(0, PB1); beat(1, PB1 + 32'h1_F000);
    rd_evts();

    cur_req = "R7";
    rd(8'h34); rd(8'h38); rd(8'h35); rd(8'h39);
    wreg(8'h38, 32'h8); rd(8'h38);
    wreg(8'h34, 32'h8000_0000); rd(8'h34);
    cyc(1, 0, PB0 + 32'h1_F000, 1, 8'h34, 32'h8000_0000); rd(8'h34);
    wreg(8'h34, 32'hFFFF_FFFF); rd(8'h34);
    wreg(8'h01, 32'h200);
    beat(0, PB0 + 32'h3000); rd(8'h34); rd(8'h19);
    wreg(8'h00, 32'h200);
    beat(0, PB0 + 32'h3000); rd(8'h34);

    cur_req = "R8";
    clr_all();
    wreg(8'h02, 32'h001);
    beat(0, 32'h1100); rd(8'h11); rd(8'h11);
    beat(1, 32'h1100); rd(8'h10); rd(8'h10); rd(8'h10);
    wreg(8'h10, 32'h0); rd(8'h10); rd(8'h10);

    cur_req = "R9";
    wreg(8'h04, 32'h100);
    beat(1, PB0 + 32'h3000); rd(8'h18); rd(8'h18); rd(8'h18);
    wreg(8'h18, 32'h0); rd(8'h18); rd(8'h18);
    wreg(8'h05, 32'h100); wreg(8'h03, 32'h001);

    cur_req = "R10";
    clr_all();
    beat(1, 32'h1000); beat(0, PB1 + 32'h7000); beat(1, PB1 + 32'h1000);
    beat(0, 32'hFFFF_0000); beat(1, 32'h0); beat(0, PB0 + 32'h3004);
    rd_evts();
    rd(8'h35); rd(8'h39); rd(8'h34);

    rd(8'h00); rd(8'h00);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule